// File: doc/BRIEF.md
# TIC Strobe and Timemark Pulse Generator

This block produces the receiver's periodic TIC strobe by dividing the master clock in two stages. A prescaler turns the master clock into a tick of about 175 ns. It divides by seven in real-input mode and by six in complex-input mode. A TIC counter then counts a programmable number of ticks per TIC period. To pull TIC into line with an external time reference, software can write a signed correction. The correction lengthens or shortens one single TIC period and is then discarded.

From the TIC strobe the block derives a timemark pulse. Software either arms one pulse for the next TIC, or requests a pulse on every n-th TIC starting with the next one. Each pulse begins one master clock after a TIC. A width counter, separate from the TIC counter, ends the pulse after a fixed number of master clocks: 40000 in real-input mode and 35000 in complex-input mode, about 1 ms in each case.

Top module: `tic_timemark_gen`

## Requirements
- R1: With a period value P, written at address 0 or taken from the reset value, `tic_o` is high for one master clock every P×7 master clocks in real-input mode.
- R2: When `cplx_mode_i` is high, the tick is six master clocks, so the TIC interval is P×6 master clocks.
- R3: A signed value A written at address 1 (bits [ADJ_W-1:0], two's complement) is held until the next TIC. The period that starts at that TIC lasts P+A ticks, with a minimum of one tick.
- R4: An adjustment applies once only. Every period after the adjusted one lasts P ticks again.
- R5: Writing address 2 with bit 8 = 0 arms a single timemark. `timemark_o` rises one master clock after the next TIC, and later TICs produce no further pulse.
- R6: Writing address 2 with bit 8 = 1 and n = bits [7:0] non-zero starts repeat mode. A pulse rises one master clock after the next TIC, and another follows every n-th TIC after that.
- R7: Writing address 2 with bit 8 = 1 and n = 0 disables the timemark, including a single shot that is still armed.
- R8: A pulse stays high for exactly PW_REAL master clocks in real-input mode, or PW_CPLX master clocks in complex-input mode.
- R9: A control write while a pulse is high neither shortens nor restarts that pulse.
- R10: During reset both outputs are low and the period is PER_RST. After reset is released, the first TIC comes after PER_RST full periods of the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cplx_mode_i | input | 1 | 1 selects complex-input mode (divide by 6, complex pulse width) |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | 0 = period, 1 = one-shot adjustment, 2 = timemark control |
| wr_data_i | input | PER_W | Write data |
| tic_o | output | 1 | TIC strobe, one master clock wide |
| timemark_o | output | 1 | Timemark pulse |

## Verification
The nominal period is measured both at its reset value and after a period write, so a wrong divider and a wrong terminal count each show up. Positive and negative adjustments are each followed across three TIC boundaries, which separates a correction that lands in the wrong period from one that persists. The timemark is driven as a single shot, as a repeat every third TIC, as a zero-n disable and as a cancel of an armed shot. Each of these gives a different rise pattern against the recorded TIC times. A control write in mid-pulse and a run in complex-input mode check that the pulse width follows only the mode.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    REG_PERIOD = 2'd0,
    REG_ADJUST = 2'd1,
    REG_TMCTL  = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  localparam int TMCTL_REP_BIT = 8;
  localparam int TMCTL_N_W     = 8;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int DIV_REAL = 7,
  parameter int DIV_CPLX = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cplx_i,
  output logic tick_o
);
  localparam int DIV_MAX = (DIV_REAL > DIV_CPLX) ? DIV_REAL : DIV_CPLX;
  localparam int CW      = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = cplx_i ? CW'(DIV_CPLX - 1) : CW'(DIV_REAL - 1);
  // >= keeps the divider safe across a mode change
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/tt_tic_counter.sv
module tt_tic_counter #(
  parameter int PER_W   = 24,
  parameter int ADJ_W   = 12,
  parameter int PER_RST = 5714286
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    per_wr_i,
  input  logic [PER_W-1:0]        per_i,
  input  logic                    adj_wr_i,
  input  logic signed [ADJ_W-1:0] adj_i,
  output logic                    tic_o
);
  localparam int LW = PER_W + 2;
  localparam int CW = PER_W + 1;

  logic [PER_W-1:0]        per_q;
  logic signed [ADJ_W-1:0] adj_pend_q, adj_act_q;
  logic [CW-1:0]           cnt_q;
  logic signed [LW-1:0]    len, term;

  assign len  = $signed({2'b00, per_q}) + {{(LW-ADJ_W){adj_act_q[ADJ_W-1]}}, adj_act_q};
  assign term = (len[LW-1] || len == '0) ? '0 : len - LW'(1);
  // >= so that a shorter period written mid-count ends at once
  assign tic_o = tick_i && ($signed({1'b0, cnt_q}) >= term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (tic_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q      <= PER_W'(PER_RST);
      adj_pend_q <= '0;
      adj_act_q  <= '0;
    end else begin
      if (per_wr_i) per_q <= per_i;
      // pending value moves into the period that starts here
      if (tic_o) begin
        adj_act_q  <= adj_pend_q;
        adj_pend_q <= '0;
      end
      if (adj_wr_i) adj_pend_q <= adj_i;
    end
  end
endmodule

// File: rtl/tt_timemark.sv
module tt_timemark #(
  parameter int N_W  = 8,
  parameter int PW_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tic_i,
  input  logic            ctl_wr_i,
  input  logic            ctl_rep_i,
  input  logic [N_W-1:0]  ctl_n_i,
  input  logic [PW_W-1:0] pw_lim_i,
  output logic            tm_o
);
  logic            arm_q, tm_q, fire;
  logic [N_W-1:0]  rep_n_q, rep_cnt_q;
  logic [PW_W-1:0] pw_cnt_q;

  assign fire = tic_i && (arm_q || (rep_n_q != '0 && rep_cnt_q == '0));
  assign tm_o = tm_q;

  // pulse width counter, independent of the schedule
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tm_q     <= 1'b0;
      pw_cnt_q <= '0;
    end else if (tm_q) begin
      if (pw_cnt_q == '0) tm_q <= 1'b0;
      else                pw_cnt_q <= pw_cnt_q - PW_W'(1);
    end else if (fire) begin
      tm_q     <= 1'b1;
      pw_cnt_q <= pw_lim_i - PW_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q     <= 1'b0;
      rep_n_q   <= '0;
      rep_cnt_q <= '0;
    end else begin
      if (tic_i) begin
        arm_q <= 1'b0;
        if (rep_n_q != '0)
          rep_cnt_q <= (rep_cnt_q == '0) ? rep_n_q - N_W'(1) : rep_cnt_q - N_W'(1);
      end
      if (ctl_wr_i) begin
        arm_q     <= !ctl_rep_i;
        rep_n_q   <= ctl_rep_i ? ctl_n_i : '0;
        rep_cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/tic_timemark_gen.sv
module tic_timemark_gen #(
  parameter int DIV_REAL = 7,
  parameter int DIV_CPLX = 6,
  parameter int PW_REAL  = 40000,
  parameter int PW_CPLX  = 35000,
  parameter int PER_W    = 24,
  parameter int ADJ_W    = 12,
  parameter int PER_RST  = 5714286
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cplx_mode_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [PER_W-1:0] wr_data_i,
  output logic             tic_o,
  output logic             timemark_o
);
  import tt_pkg::*;

  localparam int PW_MAX = (PW_REAL > PW_CPLX) ? PW_REAL : PW_CPLX;
  localparam int PW_W   = $clog2(PW_MAX + 1);

  logic            tick, tic;
  logic            per_wr, adj_wr, ctl_wr;
  logic [PW_W-1:0] pw_lim;
  reg_sel_e        sel;

  assign sel    = reg_sel_e'(wr_addr_i);
  assign per_wr = wr_en_i && (sel == REG_PERIOD);
  assign adj_wr = wr_en_i && (sel == REG_ADJUST);
  assign ctl_wr = wr_en_i && (sel == REG_TMCTL);
  assign pw_lim = cplx_mode_i ? PW_W'(PW_CPLX) : PW_W'(PW_REAL);
  assign tic_o  = tic;

  tt_prescaler #(.DIV_REAL(DIV_REAL), .DIV_CPLX(DIV_CPLX)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cplx_i (cplx_mode_i),
    .tick_o (tick)
  );

  tt_tic_counter #(.PER_W(PER_W), .ADJ_W(ADJ_W), .PER_RST(PER_RST)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .per_wr_i (per_wr),
    .per_i    (wr_data_i),
    .adj_wr_i (adj_wr),
    .adj_i    ($signed(wr_data_i[ADJ_W-1:0])),
    .tic_o    (tic)
  );

  tt_timemark #(.N_W(TMCTL_N_W), .PW_W(PW_W)) u_tm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tic_i     (tic),
    .ctl_wr_i  (ctl_wr),
    .ctl_rep_i (wr_data_i[TMCTL_REP_BIT]),
    .ctl_n_i   (wr_data_i[TMCTL_N_W-1:0]),
    .pw_lim_i  (pw_lim),
    .tm_o      (timemark_o)
  );
endmodule

// File: rtl/tic_timemark_gen_chk.sv
module tic_timemark_gen_chk #(
  parameter int PW_REAL = 40000,
  parameter int PW_CPLX = 35000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cplx_mode_i,
  input logic tick_i,
  input logic tic_o,
  input logic timemark_o
);
  int unsigned hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hi_cnt <= 0;
    else if (timemark_o) hi_cnt <= hi_cnt + 1;
    else                 hi_cnt <= 0;
  end

  a_r1_tic_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tic_o |=> !tic_o);

  a_r2_tic_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tic_o |-> tick_i);

  a_r5_rise_after_tic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timemark_o) |-> $past(tic_o));

  a_r8_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(timemark_o) |-> hi_cnt == (cplx_mode_i ? PW_CPLX : PW_REAL));
endmodule

bind tic_timemark_gen tic_timemark_gen_chk #(.PW_REAL(PW_REAL), .PW_CPLX(PW_CPLX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cplx_mode_i (cplx_mode_i),
  .tick_i      (tick),
  .tic_o       (tic_o),
  .timemark_o  (timemark_o)
);

// File: tb/tic_timemark_gen_bench.sv
module tic_timemark_gen_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PER_W = 24, ADJ_W = 12, PER_RST = 10;
  localparam int DR = 7, DC = 6, PW_R = 30, PW_C = 25;

  logic clk = 1'b0, rst_n = 1'b0, cplx = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [PER_W-1:0] wr_data = '0;
  logic tic, tm;

  always #2 clk = ~clk;

  tic_timemark_gen #(
    .DIV_REAL(DR), .DIV_CPLX(DC), .PW_REAL(PW_R), .PW_CPLX(PW_C),
    .PER_W(PER_W), .ADJ_W(ADJ_W), .PER_RST(PER_RST)
  ) u_tic_timemark_gen (
    .clk_i(clk), .rst_ni(rst_n), .cplx_mode_i(cplx), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .tic_o(tic), .timemark_o(tm)
  );

  int n_chk = 0, n_err = 0, cyc = 0, wr_tsz = 0;
  bit done = 0, tm_prev = 0;
  int tic_q[$], rise_q[$], fall_q[$];

  // behavioural reference state
  int m_pre = 0, m_tic = 0, m_per = PER_RST, m_adjp = 0, m_adja = 0;
  int m_arm = 0, m_rn = 0, m_rc = 0, m_tm = 0, m_pw = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_tic();
    int lim, len, term;
    lim  = cplx ? DC : DR;
    len  = m_per + m_adja;
    term = (len < 1) ? 0 : len - 1;
    return ((m_pre >= lim - 1) && (m_tic >= term)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_tic = 0; m_per = PER_RST; m_adjp = 0; m_adja = 0;
      m_arm = 0; m_rn = 0; m_rc = 0; m_tm = 0; m_pw = 0;
    end else begin
      int tk, tc, fire;
      tk   = (m_pre >= (cplx ? DC : DR) - 1) ? 1 : 0;
      tc   = exp_tic();
      fire = (tc != 0 && (m_arm != 0 || (m_rn != 0 && m_rc == 0))) ? 1 : 0;
      m_pre = (tk != 0) ? 0 : m_pre + 1;
      if (tc != 0) m_tic = 0; else if (tk != 0) m_tic++;
      if (tc != 0) begin m_adja = m_adjp; m_adjp = 0; end
      if (m_tm != 0) begin
        if (m_pw == 0) m_tm = 0; else m_pw--;
      end else if (fire != 0) begin
        m_tm = 1; m_pw = (cplx ? PW_C : PW_R) - 1;
      end
      if (tc != 0) begin
        m_arm = 0;
        if (m_rn != 0) m_rc = (m_rc == 0) ? m_rn - 1 : m_rc - 1;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_per = int'(wr_data);
          2'd1: m_adjp = int'($signed(wr_data[ADJ_W-1:0]));
          2'd2: begin
            m_arm = wr_data[8] ? 0 : 1;
            m_rn  = wr_data[8] ? int'(wr_data[7:0]) : 0;
            m_rc  = 0;
          end
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison and event capture, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      chk(int'(tic) == exp_tic(), "R1 per-clock tic_o", int'(tic), exp_tic());
      chk(int'(tm) == m_tm, "R8 per-clock timemark_o", int'(tm), m_tm);
    end
    if (tic) tic_q.push_back(cyc);
    if (tm && !tm_prev) rise_q.push_back(cyc);
    if (!tm && tm_prev) fall_q.push_back(cyc);
    tm_prev = tm;
  end

  task automatic wait_tics(input int n);
    int b = tic_q.size();
    while (tic_q.size() < b + n) begin @(negedge clk); #1; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [PER_W-1:0] d);
    @(negedge clk); #1;
    if (tic) begin @(negedge clk); #1; end
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    wr_tsz = tic_q.size();
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int c0, n, r0, t0, t;
    repeat (3) @(negedge clk);
    #1;
    chk(tic == 1'b0, "R10 reset tic_o", int'(tic), 0);
    chk(tm == 1'b0, "R10 reset timemark_o", int'(tm), 0);
    rst_n = 1'b1; c0 = cyc;
    wait_tics(1);
    chk(tic_q[0] - c0 == PER_RST * DR - 1, "R10 first tic", tic_q[0] - c0, PER_RST * DR - 1);
    wait_tics(2); n = tic_q.size();
    chk(tic_q[n-1] - tic_q[n-2] == 70, "R1 nominal interval", tic_q[n-1] - tic_q[n-2], 70);

    wr(2'd0, 24'd12); wait_tics(3); n = tic_q.size();
    chk(tic_q[n-1] - tic_q[n-2] == 84, "R1 written period", tic_q[n-1] - tic_q[n-2], 84);
    wr(2'd0, 24'd10); wait_tics(2);

    // positive and negative one-period corrections
    wr(2'd1, 24'd3); wait_tics(3); n = tic_q.size();
    chk(tic_q[n-2] - tic_q[n-3] == 91, "R3 longer period", tic_q[n-2] - tic_q[n-3], 91);
    chk(tic_q[n-1] - tic_q[n-2] == 70, "R4 back to nominal", tic_q[n-1] - tic_q[n-2], 70);
    wr(2'd1, 24'hFFFFFC); wait_tics(3); n = tic_q.size();
    chk(tic_q[n-2] - tic_q[n-3] == 42, "R3 shorter period", tic_q[n-2] - tic_q[n-3], 42);
    chk(tic_q[n-1] - tic_q[n-2] == 70, "R4 back to nominal", tic_q[n-1] - tic_q[n-2], 70);

    // single shot
    r0 = rise_q.size();
    wr(2'd2, 24'h000); t0 = wr_tsz; wait_tics(1); idle(40);
    t = tic_q[t0];
    chk(rise_q.size() == r0 + 1, "R5 one pulse", rise_q.size() - r0, 1);
    chk(rise_q[r0] == t + 1, "R5 start after tic", rise_q[r0], t + 1);
    chk(fall_q[r0] - rise_q[r0] == PW_R, "R8 real width", fall_q[r0] - rise_q[r0], PW_R);
    wait_tics(3);
    chk(rise_q.size() == r0 + 1, "R5 no repeat", rise_q.size() - r0, 1);

    // repeat every third TIC
    r0 = rise_q.size();
    wr(2'd2, 24'h103); t0 = wr_tsz; wait_tics(7); idle(40);
    chk(rise_q.size() == r0 + 3, "R6 pulse count", rise_q.size() - r0, 3);
    chk(rise_q[r0] == tic_q[t0] + 1, "R6 first at next tic", rise_q[r0], tic_q[t0] + 1);
    chk(rise_q[r0+1] - rise_q[r0] == 210, "R6 spacing", rise_q[r0+1] - rise_q[r0], 210);
    chk(rise_q[r0+2] - rise_q[r0+1] == 210, "R6 spacing", rise_q[r0+2] - rise_q[r0+1], 210);

    // n = 0 disables, and cancels an armed shot
    wr(2'd2, 24'h100); idle(40); r0 = rise_q.size();
    wait_tics(4);
    chk(rise_q.size() == r0, "R7 repeat disabled", rise_q.size() - r0, 0);
    wait_tics(1);
    wr(2'd2, 24'h000); wr(2'd2, 24'h100); r0 = rise_q.size();
    wait_tics(2); idle(40);
    chk(rise_q.size() == r0, "R7 shot cancelled", rise_q.size() - r0, 0);

    // control write in mid-pulse
    r0 = rise_q.size();
    wr(2'd2, 24'h000); wait_tics(1); idle(5);
    wr(2'd2, 24'h100); idle(40);
    chk(rise_q.size() == r0 + 1, "R9 single pulse", rise_q.size() - r0, 1);
    chk(fall_q[r0] - rise_q[r0] == PW_R, "R9 width kept", fall_q[r0] - rise_q[r0], PW_R);

    // complex-input mode
    @(negedge clk); #1;
    rst_n = 1'b0; cplx = 1'b1;
    idle(2);
    rst_n = 1'b1;
    wait_tics(3); n = tic_q.size();
    chk(tic_q[n-1] - tic_q[n-2] == 60, "R2 complex interval", tic_q[n-1] - tic_q[n-2], 60);
    r0 = rise_q.size();
    wr(2'd2, 24'h000); t0 = wr_tsz; wait_tics(1); idle(40);
    chk(rise_q[r0] == tic_q[t0] + 1, "R5 complex start", rise_q[r0], tic_q[t0] + 1);
    chk(fall_q[r0] - rise_q[r0] == PW_C, "R8 complex width", fall_q[r0] - rise_q[r0], PW_C);

    finish_run();
  end
endmodule